// File: doc/BRIEF.md
# Address-Window Chip Select

This block drives a chip-select line for one external device whose location in a 28-bit address space is set by software. An access hits the window when its upper twelve address bits equal a stored high-address value, its lower sixteen bits fall between a start bound and a stop bound (both inclusive), and its direction is enabled in a mode register. When the device is marked 16-bit wide, the lowest address bit takes no part in the range test, so a bound that sits at an odd address covers the whole halfword around it.

Four 16-bit configuration registers sit behind a small write/read port with a 2-bit index. Two reset inputs are provided. `rtc_rst_ni` wipes the configuration. `rst_ni` only clears the registered select output, so the window programming survives an ordinary system reset. A parameter chooses whether the select leaves the block straight from the comparators or through one flip-flop.

Top module: `addr_window_cs`

## Requirements
- R1: Select requires address bits 27:16 to equal bits 11:0 of the high-address register (index 0) exactly.
- R2: Bits 15:12 of the high-address register ignore writes and always read back as zero.
- R3: Select requires start <= address[15:0] <= stop, both bounds inclusive (start at index 1, stop at index 2).
- R4: Mode register (index 3) bit 0 enables reads, and bit 1 enables writes (`bus_write_i`=1). An access of a disabled direction never selects. With both bits clear, select never asserts.
- R5: When mode bit 2 (16-bit device) is set, address bit 0 and bit 0 of both bounds are left out of the range comparison.
- R6: While `rtc_rst_ni` is low, all configuration registers are zero.
- R7: Asserting `rst_ni` leaves every configuration register at its previous value.
- R8: When start exceeds stop (taken without bit 0 in 16-bit mode), no address selects.
- R9: Select is low whenever `bus_valid_i` is low.
- R10: A write to index 0..3 takes effect at the next clock edge and reads back through `reg_rdata_o` in the same cycle the index is presented. Mode bits 15:3 read as zero.
- R11: With `REG_OUT`=1, `cs_o` shows the match one clock after the access is presented and is cleared by `rst_ni`. With `REG_OUT`=0, it follows the access in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset; clears the output stage only |
| rtc_rst_ni | input | 1 | Asynchronous active-low configuration reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 2 | Register index: 0 high, 1 start, 2 stop, 3 mode |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_idx_i` |
| bus_valid_i | input | 1 | Bus cycle valid |
| bus_addr_i | input | 28 | Bus address |
| bus_write_i | input | 1 | Access direction, 1 = write |
| cs_o | output | 1 | Chip select, active high |

## Verification
The bench builds two copies of the block from the same stimulus. One copy uses the default `REG_OUT`=1 and the other uses `REG_OUT`=0. Both are compared on every access, so the same-cycle comparator result and the one-cycle-late registered select are each checked against one expected value. The 16-bit option is a mode bit rather than a parameter. Running both reset inputs against the same build shows that the configuration survives `rst_ni` while the registered select is still cleared by it.

// File: rtl/addr_cs_pkg.sv
package addr_cs_pkg;
  typedef enum logic [1:0] {
    IDX_HIGH  = 2'd0,
    IDX_START = 2'd1,
    IDX_STOP  = 2'd2,
    IDX_MODE  = 2'd3
  } reg_idx_e;

  localparam int MODE_BITS = 3;

  typedef struct packed {
    logic wide;   // bit 2
    logic wr_en;  // bit 1
    logic rd_en;  // bit 0
  } mode_t;
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import addr_cs_pkg::*;
#(
  parameter int HIGH_W = 12,
  parameter int LOW_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rtc_rst_ni,
  input  logic              we_i,
  input  logic [1:0]        idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [HIGH_W-1:0] high_o,
  output logic [LOW_W-1:0]  start_o,
  output logic [LOW_W-1:0]  stop_o,
  output mode_t             mode_o
);
  logic [HIGH_W-1:0] high_q;
  logic [LOW_W-1:0]  start_q, stop_q;
  mode_t             mode_q;

  // only the configuration reset clears these; the system reset must not
  always_ff @(posedge clk_i or negedge rtc_rst_ni) begin
    if (!rtc_rst_ni) begin
      high_q  <= '0;
      start_q <= '0;
      stop_q  <= '0;
      mode_q  <= '0;
    end else if (we_i) begin
      unique case (reg_idx_e'(idx_i))
        IDX_HIGH:  high_q  <= wdata_i[HIGH_W-1:0];
        IDX_START: start_q <= wdata_i[LOW_W-1:0];
        IDX_STOP:  stop_q  <= wdata_i[LOW_W-1:0];
        IDX_MODE:  mode_q  <= mode_t'(wdata_i[MODE_BITS-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_idx_e'(idx_i))
      IDX_HIGH:  rdata_o[HIGH_W-1:0]    = high_q;
      IDX_START: rdata_o[LOW_W-1:0]     = start_q;
      IDX_STOP:  rdata_o[LOW_W-1:0]     = stop_q;
      IDX_MODE:  rdata_o[MODE_BITS-1:0] = mode_q;
      default: ;
    endcase
  end

  assign high_o  = high_q;
  assign start_o = start_q;
  assign stop_o  = stop_q;
  assign mode_o  = mode_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:MODE_BITS];

  p_write_start_r10: assert property (@(posedge clk_i) disable iff (!rtc_rst_ni)
    (we_i && idx_i == IDX_START) |=> start_q == $past(wdata_i[LOW_W-1:0]));
  p_write_mode_r10: assert property (@(posedge clk_i) disable iff (!rtc_rst_ni)
    (we_i && idx_i == IDX_MODE) |=> mode_q == $past(wdata_i[MODE_BITS-1:0]));
  p_hold_cfg_r7: assert property (@(posedge clk_i) disable iff (!rtc_rst_ni)
    !we_i |=> ($stable(high_q) && $stable(start_q) && $stable(stop_q) && $stable(mode_q)));
  p_rtc_clear_r6: assert property (@(posedge clk_i)
    !rtc_rst_ni |-> (high_q == '0 && start_q == '0 && stop_q == '0 && mode_q == '0));
endmodule

// File: rtl/cs_window_match.sv
module cs_window_match
  import addr_cs_pkg::*;
#(
  parameter int HIGH_W = 12,
  parameter int LOW_W  = 16,
  localparam int ADDR_W = HIGH_W + LOW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HIGH_W-1:0] high_i,
  input  logic [LOW_W-1:0]  start_i,
  input  logic [LOW_W-1:0]  stop_i,
  input  mode_t             mode_i,
  output logic              hit_o
);
  logic [LOW_W-1:0] lo_m, start_m, stop_m;
  logic             high_eq, in_range, dir_ok;

  // 16-bit device: drop bit 0 from all three operands
  always_comb begin
    lo_m    = addr_i[LOW_W-1:0];
    start_m = start_i;
    stop_m  = stop_i;
    if (mode_i.wide) begin
      lo_m[0]    = 1'b0;
      start_m[0] = 1'b0;
      stop_m[0]  = 1'b0;
    end
  end

  assign high_eq  = addr_i[ADDR_W-1:LOW_W] == high_i;
  assign in_range = (lo_m >= start_m) && (lo_m <= stop_m);
  assign dir_ok   = write_i ? mode_i.wr_en : mode_i.rd_en;
  assign hit_o    = valid_i && high_eq && in_range && dir_ok;

  p_no_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !hit_o);
  p_dir_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (write_i ? mode_i.wr_en : mode_i.rd_en));
  p_empty_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i.wide && start_i > stop_i) |-> !hit_o);
  p_high_eq_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> addr_i[ADDR_W-1:LOW_W] == high_i);
endmodule

// File: rtl/cs_out_stage.sv
module cs_out_stage #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic cs_o
);
  if (REG_OUT) begin : g_reg
    logic cs_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cs_q <= 1'b0;
      else         cs_q <= hit_i;
    end
    assign cs_o = cs_q;

    p_lat_hit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i |=> cs_o);
    p_lat_miss_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_i |=> !cs_o);
  end else begin : g_comb
    assign cs_o = hit_i;
  end
endmodule

// File: rtl/addr_window_cs.sv
module addr_window_cs
  import addr_cs_pkg::*;
#(
  parameter int HIGH_W  = 12,
  parameter int LOW_W   = 16,
  parameter int DATA_W  = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int ADDR_W = HIGH_W + LOW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rtc_rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_idx_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_write_i,
  output logic              cs_o
);
  logic [HIGH_W-1:0] high;
  logic [LOW_W-1:0]  start, stop;
  mode_t             mode;
  logic              hit;

  cs_cfg_regs #(.HIGH_W(HIGH_W), .LOW_W(LOW_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i, .rtc_rst_ni,
    .we_i(reg_we_i), .idx_i(reg_idx_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .high_o(high), .start_o(start), .stop_o(stop), .mode_o(mode)
  );

  cs_window_match #(.HIGH_W(HIGH_W), .LOW_W(LOW_W)) u_match (
    .clk_i, .rst_ni,
    .valid_i(bus_valid_i), .write_i(bus_write_i), .addr_i(bus_addr_i),
    .high_i(high), .start_i(start), .stop_i(stop), .mode_i(mode), .hit_o(hit)
  );

  cs_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk_i, .rst_ni, .hit_i(hit), .cs_o
  );
endmodule

// File: tb/addr_window_cs_test.sv
`timescale 1ns/1ps
module addr_window_cs_test;
  logic        clk = 0, rst_ni = 0, rtc_rst_ni = 0;
  logic        we = 0, valid = 0, wr = 0;
  logic [1:0]  idx = 0;
  logic [15:0] wdata = 0;
  logic [27:0] addr = 0;
  logic [15:0] rdata, rdata_c;
  logic        cs, cs_c;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  addr_window_cs uut (
    .clk_i(clk), .rst_ni, .rtc_rst_ni, .reg_we_i(we), .reg_idx_i(idx),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .bus_valid_i(valid),
    .bus_addr_i(addr), .bus_write_i(wr), .cs_o(cs));

  addr_window_cs #(.REG_OUT(1'b0)) uut_comb (
    .clk_i(clk), .rst_ni, .rtc_rst_ni, .reg_we_i(we), .reg_idx_i(idx),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_c), .bus_valid_i(valid),
    .bus_addr_i(addr), .bus_write_i(wr), .cs_o(cs_c));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] i, logic [15:0] d);
    @(negedge clk); we = 1; idx = i; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rreg(string tag, logic [1:0] i, logic [15:0] exp);
    @(negedge clk); idx = i; #1;
    chk(tag, rdata, exp);
  endtask

  // both outputs must equal exp: comb in the cycle, registered after the edge
  task automatic access(string tag, logic [27:0] a, logic w, logic exp);
    @(negedge clk); valid = 1; addr = a; wr = w; #1;
    chk({tag, " comb"}, cs_c, exp);
    @(posedge clk); #1;
    chk({tag, " reg"}, cs, exp);
  endtask

  task automatic t_reset_state;
    rreg("R6 high after rtc reset", 0, 16'h0);
    rreg("R6 start after rtc reset", 1, 16'h0);
    rreg("R6 mode after rtc reset", 3, 16'h0);
    chk("R11 cs after reset", cs, 0);
  endtask

  task automatic t_regs;
    wreg(0, 16'hFABC); rreg("R2 high reserved bits", 0, 16'h0ABC);
    wreg(1, 16'h1234); rreg("R10 start readback", 1, 16'h1234);
    wreg(2, 16'hBEEF); rreg("R10 stop readback", 2, 16'hBEEF);
    wreg(3, 16'hFFFF); rreg("R10 mode reserved bits", 3, 16'h0007);
  endtask

  task automatic t_window;
    wreg(0, 16'h0A5); wreg(1, 16'h1000); wreg(2, 16'h1FFF); wreg(3, 16'h3);
    access("R3 at start", {12'h0A5, 16'h1000}, 0, 1);
    access("R3 at stop", {12'h0A5, 16'h1FFF}, 1, 1);
    access("R3 below start", {12'h0A5, 16'h0FFF}, 0, 0);
    access("R3 above stop", {12'h0A5, 16'h2000}, 0, 0);
    access("R1 high off by one", {12'h0A4, 16'h1800}, 0, 0);
    access("R1 high top bit", {12'h8A5, 16'h1800}, 0, 0);
  endtask

  task automatic t_dir;
    wreg(3, 16'h1);
    access("R4 read enabled", {12'h0A5, 16'h1800}, 0, 1);
    access("R4 write disabled", {12'h0A5, 16'h1800}, 1, 0);
    wreg(3, 16'h2);
    access("R4 write enabled", {12'h0A5, 16'h1800}, 1, 1);
    access("R4 read disabled", {12'h0A5, 16'h1800}, 0, 0);
    wreg(3, 16'h0);
    access("R4 none enabled rd", {12'h0A5, 16'h1800}, 0, 0);
    access("R4 none enabled wr", {12'h0A5, 16'h1800}, 1, 0);
  endtask

  task automatic t_wide;
    wreg(1, 16'h0011); wreg(2, 16'h0020); wreg(3, 16'h3);
    access("R5 8-bit below odd start", {12'h0A5, 16'h0010}, 0, 0);
    access("R5 8-bit past stop", {12'h0A5, 16'h0021}, 0, 0);
    wreg(3, 16'h7);
    access("R5 16-bit low half of start", {12'h0A5, 16'h0010}, 0, 1);
    access("R5 16-bit high half of stop", {12'h0A5, 16'h0021}, 1, 1);
    access("R5 16-bit past stop", {12'h0A5, 16'h0022}, 0, 0);
  endtask

  task automatic t_empty;
    wreg(1, 16'h3000); wreg(2, 16'h2000); wreg(3, 16'h3);
    access("R8 between", {12'h0A5, 16'h2800}, 0, 0);
    access("R8 at start", {12'h0A5, 16'h3000}, 0, 0);
    access("R8 at stop", {12'h0A5, 16'h2000}, 0, 0);
  endtask

  task automatic t_valid_latency;
    wreg(1, 16'h1000); wreg(2, 16'h1FFF);
    access("R11 prior miss", {12'h0A5, 16'h0000}, 0, 0);
    @(negedge clk); valid = 1; addr = {12'h0A5, 16'h1500}; wr = 0; #1;
    chk("R11 comb same cycle", cs_c, 1);
    chk("R11 reg not yet", cs, 0);
    @(posedge clk); #1;
    chk("R11 reg next cycle", cs, 1);
    @(negedge clk); valid = 0; #1;
    chk("R9 comb idle", cs_c, 0);
    @(posedge clk); #1;
    chk("R9 reg idle", cs, 0);
  endtask

  task automatic t_resets;
    @(negedge clk); valid = 1; addr = {12'h0A5, 16'h1500}; wr = 0;
    @(posedge clk); #1;
    chk("R11 cs before reset", cs, 1);
    @(negedge clk); rst_ni = 0; #1;
    chk("R11 rst clears cs", cs, 0);
    @(negedge clk); rst_ni = 1; valid = 0;
    rreg("R7 high kept", 0, 16'h0A5);
    rreg("R7 start kept", 1, 16'h1000);
    rreg("R7 stop kept", 2, 16'h1FFF);
    rreg("R7 mode kept", 3, 16'h3);
    @(negedge clk); rtc_rst_ni = 0;
    rreg("R6 high cleared", 0, 16'h0);
    rreg("R6 stop cleared", 2, 16'h0);
    rreg("R6 mode cleared", 3, 16'h0);
    @(negedge clk); rtc_rst_ni = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1; rtc_rst_ni = 1;
    t_reset_state();
    t_regs();
    t_window();
    t_dir();
    t_wide();
    t_empty();
    t_valid_latency();
    t_resets();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule